// File: doc/BRIEF.md
# Throttle Fan-In Aligner

This block collects one back-pressure (throttle) bit from each readout board attached to an aggregator. Because the boards are connected over links of different latency, each bit first goes through its own delay line. The delay of each line is set between 0 and 15 clocks, so that every bit of the assembled word refers to the same bunch crossing. On every clock, the aligned bits are packed into a throttle vector for the central supervisor. Each vector is tagged with the crossing identifier captured at the same edge and comes with a summary flag that is the OR of all enabled bits.

A lane-enable mask silences boards that are absent or excluded. A masked board reads as zero in the vector, does not contribute to the flag and is not counted. A per-lane counter keeps track of how many clocks each board has spent throttling. Any one counter can be read through a lane-select port. A valid strobe stays low after reset until every delay line holds only post-reset history.

Top module: `throttle_fanin_aligner`

## Requirements
- R1: After the clock edge k, bit i of `word_out` equals `thr_in[i]` as sampled at edge k-d, where d is the unsigned delay field `dly_cfg[4*i+3:4*i]` (0 to 15) in effect at edge k. Samples from before reset count as 0.
- R2: After the clock edge k, `word_bx` equals `bx_in` sampled at edge k.
- R3: When `lane_en[i]` is 0 at an edge, bit i of the word registered at that edge is 0. That lane then adds nothing to `any_out` and nothing to its counter.
- R4: `any_out` is 1 exactly when at least one bit of `word_out` is 1, in the same cycle.
- R5: `word_vld` is 0 for the first 15 edges after reset and 1 from the 16th edge onward, until the next reset.
- R6: Counter i is incremented by one at each edge that registers bit i of the word as 1. `rd_cnt` shows counter `rd_sel` with no clock delay.
- R7: A counter that reaches 2^CNT_W-1 (1023 by default) stays there.
- R8: A `rd_sel` value of LANES or more reads 0.
- R9: While `rst_n` is low, `word_out`, `word_bx`, `any_out`, `word_vld` and every counter are 0, and all delay-line history is cleared.
- R10: A change of a lane's delay field takes effect at the next edge. The tap is taken from the full 15-sample history, which is kept whatever the current setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| thr_in | input | LANES | One raw throttle bit per board |
| bx_in | input | BX_W | Current crossing identifier |
| dly_cfg | input | LANES*DLY_W | Per-lane delay in clocks, lane i at bits [DLY_W*i +: DLY_W] |
| lane_en | input | LANES | Per-lane enable mask |
| rd_sel | input | SEL_W | Lane whose hold counter is shown on rd_cnt |
| word_out | output | LANES | Aligned, masked throttle vector |
| word_bx | output | BX_W | Crossing identifier tagged to word_out |
| any_out | output | 1 | OR of the bits of word_out |
| word_vld | output | 1 | Delay history fully populated since reset |
| rd_cnt | output | CNT_W | Hold count of the selected lane |

## Verification
The assertions assume that `rst_n` is released away from an active clock edge. They also assume that `lane_en` and `dly_cfg` carry defined levels in every cycle, so that `$past` of the mask is meaningful from the first edge after reset. The stimulus drives every input 1 ns after the falling edge and keeps all inputs at defined values from time zero. This includes the reset cycles and a second reset applied mid-run. The stimulus changes delay fields while traffic flows, enables random subsets of lanes and sweeps `rd_sel` through values beyond the lane count. It also holds one lane high long enough for its counter to saturate.

// File: rtl/tfa_pkg.sv
package tfa_pkg;
  parameter int unsigned TFA_LANES = 20;
  parameter int unsigned TFA_DLY_W = 4;
  parameter int unsigned TFA_BX_W  = 12;
  parameter int unsigned TFA_CNT_W = 10;
endpackage

// File: rtl/tfa_lane.sv
module tfa_lane #(
  parameter int unsigned DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic             en_i,
  output logic             tap_o
);
  localparam int unsigned MAX_DLY = (1 << DLY_W) - 1;

  logic [MAX_DLY-1:0] sr_q;
  logic [MAX_DLY-1:0] sr_d;
  logic [MAX_DLY:0]   hist;

  // hist[0] is the current sample, hist[j] the sample taken j edges ago
  always_comb begin
    hist  = {sr_q, din_i};
    sr_d  = hist[MAX_DLY-1:0];
    tap_o = hist[dly_i] & en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end
endmodule

// File: rtl/tfa_hold_cnt.sv
module tfa_hold_cnt #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = inc_i && (cnt_q != '1);
    cnt_d  = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  assert_cnt_no_decrease_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q >= $past(cnt_q));

  assert_cnt_saturates_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_q) == {CNT_W{1'b1}}) |-> (cnt_q == {CNT_W{1'b1}}));
endmodule

// File: rtl/tfa_fill.sv
module tfa_fill #(
  parameter int unsigned DLY_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic vld_o
);
  logic [DLY_W-1:0] fill_q, fill_d;
  logic             vld_q, vld_d;

  always_comb begin
    fill_d = fill_q;
    vld_d  = vld_q;
    if (!vld_q) begin
      if (fill_q == '1) vld_d  = 1'b1;
      else              fill_d = fill_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      fill_q <= fill_d;
      vld_q  <= vld_d;
    end
  end

  assign vld_o = vld_q;

  assert_vld_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> vld_q);
endmodule

// File: rtl/throttle_fanin_aligner.sv
module throttle_fanin_aligner
  import tfa_pkg::*;
#(
  parameter int unsigned LANES = TFA_LANES,
  parameter int unsigned DLY_W = TFA_DLY_W,
  parameter int unsigned BX_W  = TFA_BX_W,
  parameter int unsigned CNT_W = TFA_CNT_W,
  localparam int unsigned SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LANES-1:0]       thr_in,
  input  logic [BX_W-1:0]        bx_in,
  input  logic [LANES*DLY_W-1:0] dly_cfg,
  input  logic [LANES-1:0]       lane_en,
  input  logic [SEL_W-1:0]       rd_sel,
  output logic [LANES-1:0]       word_out,
  output logic [BX_W-1:0]        word_bx,
  output logic                   any_out,
  output logic                   word_vld,
  output logic [CNT_W-1:0]       rd_cnt
);
  logic [LANES-1:0] tap_w;
  logic [CNT_W-1:0] cnt_arr [LANES];

  logic [LANES-1:0] word_q, word_d;
  logic [BX_W-1:0]  bx_q, bx_d;
  logic             any_q, any_d;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    tfa_lane #(.DLY_W(DLY_W)) u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .din_i (thr_in[g]),
      .dly_i (dly_cfg[g*DLY_W +: DLY_W]),
      .en_i  (lane_en[g]),
      .tap_o (tap_w[g])
    );
    tfa_hold_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc_i (tap_w[g]),
      .cnt_o (cnt_arr[g])
    );
  end

  tfa_fill #(.DLY_W(DLY_W)) u_fill (
    .clk   (clk),
    .rst_n (rst_n),
    .vld_o (word_vld)
  );

  always_comb begin
    word_d = tap_w;
    any_d  = |tap_w;
    bx_d   = bx_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      bx_q   <= '0;
      any_q  <= 1'b0;
    end else begin
      word_q <= word_d;
      bx_q   <= bx_d;
      any_q  <= any_d;
    end
  end

  always_comb begin
    rd_cnt = '0;
    for (int i = 0; i < LANES; i++) begin
      if (rd_sel == SEL_W'(i)) rd_cnt = cnt_arr[i];
    end
  end

  assign word_out = word_q;
  assign word_bx  = bx_q;
  assign any_out  = any_q;

  assert_masked_lane_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (word_q & ~$past(lane_en)) == '0);

  assert_flag_tracks_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    any_q == (word_q != '0));

  assert_sel_out_of_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(rd_sel) >= LANES) |-> (rd_cnt == '0));
endmodule

// File: tb/sim_throttle_fanin_aligner.sv
`timescale 1ns/1ps
module sim_throttle_fanin_aligner;
  localparam int LANES = 20;
  localparam int DLY_W = 4;
  localparam int BX_W  = 12;
  localparam int CNT_W = 10;
  localparam int SEL_W = 5;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic [LANES-1:0]       thr_in = '0;
  logic [BX_W-1:0]        bx_in = '0;
  logic [LANES*DLY_W-1:0] dly_cfg = '0;
  logic [LANES-1:0]       lane_en = '1;
  logic [SEL_W-1:0]       rd_sel = '0;
  logic [LANES-1:0]       word_out;
  logic [BX_W-1:0]        word_bx;
  logic                   any_out;
  logic                   word_vld;
  logic [CNT_W-1:0]       rd_cnt;

  throttle_fanin_aligner u0 (
    .clk(clk), .rst_n(rst_n), .thr_in(thr_in), .bx_in(bx_in), .dly_cfg(dly_cfg),
    .lane_en(lane_en), .rd_sel(rd_sel), .word_out(word_out), .word_bx(word_bx),
    .any_out(any_out), .word_vld(word_vld), .rd_cnt(rd_cnt)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // behavioural reference: per-lane history queues and plain counters
  bit               hq [LANES][$];
  int               cm [LANES];
  int               edges;
  logic [LANES-1:0] e_word;
  logic [BX_W-1:0]  e_bx;
  logic             e_any, e_vld;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LANES; i++) begin
        hq[i].delete();
        for (int j = 0; j < 15; j++) hq[i].push_back(1'b0);
        cm[i] = 0;
      end
      edges = 0; e_word = '0; e_bx = '0; e_any = 1'b0; e_vld = 1'b0;
    end else begin
      for (int i = 0; i < LANES; i++) begin
        int d;
        bit t;
        d = int'(dly_cfg[i*DLY_W +: DLY_W]);
        t = (d == 0) ? thr_in[i] : hq[i][d-1];
        e_word[i] = t & lane_en[i];
        if (e_word[i] && cm[i] < CMAX) cm[i]++;
        hq[i].push_front(thr_in[i]);
        void'(hq[i].pop_back());
      end
      e_bx  = bx_in;
      e_any = (e_word != '0);
      edges++;
      e_vld = (edges >= 16);
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      int ec;
      ec = (int'(rd_sel) < LANES) ? cm[rd_sel] : 0;
      n_chk++;
      if (word_out !== e_word) begin
        n_bad++; $display("FAIL R1/R3/R9/R10 word_out actual %h expected %h", word_out, e_word);
      end
      n_chk++;
      if (word_bx !== e_bx) begin
        n_bad++; $display("FAIL R2 word_bx actual %h expected %h", word_bx, e_bx);
      end
      n_chk++;
      if (any_out !== e_any) begin
        n_bad++; $display("FAIL R4 any_out actual %b expected %b", any_out, e_any);
      end
      n_chk++;
      if (word_vld !== e_vld) begin
        n_bad++; $display("FAIL R5 word_vld actual %b expected %b", word_vld, e_vld);
      end
      n_chk++;
      if (int'(rd_cnt) != ec) begin
        n_bad++; $display("FAIL R6/R7/R8 rd_cnt sel %0d actual %0d expected %0d", rd_sel, rd_cnt, ec);
      end
    end
  end

  task automatic rnd_dly();
    for (int i = 0; i < LANES; i++) dly_cfg[i*DLY_W +: DLY_W] = DLY_W'($urandom);
  endtask

  // mode 0: random bits; mode 1: lane 3 held high
  task automatic run(int cycles, int mode, int dly_period);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk); #1;
      thr_in = LANES'($urandom);
      if (mode == 1) begin thr_in[3] = 1'b1; rd_sel = 5'd3; end
      else rd_sel = SEL_W'(c % 32);
      bx_in = bx_in + 1'b1;
      if (dly_period > 0 && (c % dly_period) == 0) rnd_dly();  // R10
    end
  endtask

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    // R1 R2 R5: zero delay, all lanes enabled
    run(100, 0, 0);
    // R1: fixed random delays
    rnd_dly();
    run(300, 0, 0);
    // R3 R10: random masks, delays changing on the fly
    for (int k = 0; k < 6; k++) begin
      lane_en = LANES'($urandom);
      run(50, 0, 7);
    end
    // R6 R7: lane 3 held high until saturation
    lane_en = '1;
    run(1100, 1, 0);
    // R8 R9: sweep selects, then reset mid-run
    run(40, 0, 0);
    @(negedge clk); #1 rst_n = 1'b0;
    repeat (2) @(negedge clk);
    #1 rst_n = 1'b1;
    lane_en = LANES'($urandom);
    run(60, 0, 5);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule